// File: doc/BRIEF.md
# Twelve-Pin GPIO Controller with Level Interrupts

This block drives and samples twelve general-purpose pins from a plain 32-bit register bus. The bus has a word address, a write strobe, write data and combinational read data. Software sets the output values and the per-pin output enables. It reads back the pin levels after a two-flop synchronizer.

Each pin can raise a level-sensitive interrupt, active high or active low by choice. While the synchronized level is active, the pin's bit in a sticky status register is set. Software acknowledges the bit by writing a one to it, and the bit sets again as long as the level stays active. A per-pin enable mask gates the status bits into one interrupt output. A 32-bit multiplexer-control word is also held; it is plain storage with no effect on the pins.

Top module: `gpio_level_irq`

## Requirements
- R1: After reset, output data, output enable, interrupt enable, polarity, status and mux-control registers all read zero, and `pin_out`, `pin_oe` and `irq` are low.
- R2: Word 0x00 holds the output data and word 0x04 the output enables, 12 bits each. `pin_out` and `pin_oe` follow them from the cycle after the write. Bits 31:12 read as zero.
- R3: Word 0x08 returns the pin levels after two clock edges of synchronization. Bits 31:12 read as zero, and writes to this word have no effect.
- R4: The polarity of pin n is bit 4*(n mod 8): in word 0x10 for pins 0 to 7 and in word 0x18 for pins 8 to 11. All other bits of these words read zero and are ignored on write.
- R5: Polarity 0 makes a synchronized high level active, and polarity 1 a low level. The status bit (word 0x0C) sets on the clock edge after the synchronized level is active, whatever the mask.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged, and no bit clears without such a write.
- R7: If a pin is still active when its bit is acknowledged, the bit reads 0 for one cycle and sets again on the following edge.
- R8: Word 0x14 holds the interrupt enables (1 = enabled). `irq` is high exactly when some status bit has its enable set.
- R9: Word 0x1C is a 32-bit read/write register with no effect on pins, status or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 12 | Pin levels (asynchronous) |
| pin_out | output | 12 | Pin output values |
| pin_oe | output | 12 | Pin output enables (1 = drive) |
| irq | output | 1 | Combined level interrupt |

## Verification
A wrong polarity or synchronizer state shows as a status bit that sets one edge early or late, or not at all. The bench checks this on the exact edge, three edges after a pin change. A status latch that does not re-arm, or clears on a zero write, shows in the readback of word 0x0C within one cycle of the acknowledge. A mask fault shows at once on `irq`, because it is combinational from the status and enable registers.

// File: rtl/gpio_level_irq.sv
module gpio_level_irq #(
  parameter int NPIN = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [11:0] pin_in,
  output logic [11:0] pin_out,
  output logic [11:0] pin_oe,
  output logic        irq
);
  localparam logic [2:0] W_DOUT = 3'd0, W_OE = 3'd1, W_DIN = 3'd2, W_STAT = 3'd3,
                         W_POLLO = 3'd4, W_EN = 3'd5, W_POLHI = 3'd6, W_MUX = 3'd7;
  localparam int LOGRP = 8;

  logic [NPIN-1:0] dout_q, oe_q, en_q, pol_q, stat_q, s1_q, s2_q;
  logic [31:0]     mux_q;
  logic [31:0]     pol_lo_rd, pol_hi_rd;

  wire [2:0]      wsel   = bus_addr[4:2];
  wire            wr     = bus_we;
  wire [NPIN-1:0] active = s2_q ^ pol_q;
  wire [NPIN-1:0] ack    = (wr && wsel == W_STAT) ? bus_wdata[NPIN-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= '0;
      en_q   <= '0;
      mux_q  <= '0;
    end else if (wr) begin
      case (wsel)
        W_DOUT:  dout_q <= bus_wdata[NPIN-1:0];
        W_OE:    oe_q   <= bus_wdata[NPIN-1:0];
        W_EN:    en_q   <= bus_wdata[NPIN-1:0];
        W_MUX:   mux_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
    end else begin
      for (int i = 0; i < NPIN; i++) begin
        if (wr && ((wsel == W_POLLO && i < LOGRP) || (wsel == W_POLHI && i >= LOGRP)))
          pol_q[i] <= bus_wdata[4*(i%LOGRP)];
      end
    end
  end

  // acknowledge wins for its cycle; a still-active level re-latches on the next edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q | active) & ~ack;
  end

  always_comb begin
    pol_lo_rd = '0;
    pol_hi_rd = '0;
    for (int i = 0; i < NPIN; i++) begin
      if (i < LOGRP) pol_lo_rd[4*(i%LOGRP)] = pol_q[i];
      else           pol_hi_rd[4*(i%LOGRP)] = pol_q[i];
    end
  end

  always_comb begin
    case (wsel)
      W_DOUT:  bus_rdata = 32'(dout_q);
      W_OE:    bus_rdata = 32'(oe_q);
      W_DIN:   bus_rdata = 32'(s2_q);
      W_STAT:  bus_rdata = 32'(stat_q);
      W_POLLO: bus_rdata = pol_lo_rd;
      W_EN:    bus_rdata = 32'(en_q);
      W_POLHI: bus_rdata = pol_hi_rd;
      default: bus_rdata = mux_q;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = oe_q;
  assign irq     = |(stat_q & en_q);

  assert_oe_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[4:2] == W_OE) |=> (pin_oe == $past(bus_wdata[11:0])));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr[4:2] == W_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[4:2] == W_STAT) |=> ((stat_q & $past(bus_wdata[NPIN-1:0])) == '0));

  assert_mask_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[4:2] == W_EN && bus_wdata[11:0] == 12'h000) |=> !irq);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[4:2] != W_MUX && bus_addr[4:2] != W_POLLO) |-> (bus_rdata[31:16] == 16'h0));
endmodule

// File: tb/tb_gpio_level_irq.sv
`timescale 1ns/1ps
module tb_gpio_level_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_level_irq dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {addr, write data, expected readback}
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h0000_0FFF},
    {8'h00, 32'h0000_0A5A, 32'h0000_0A5A},
    {8'h04, 32'hFFFF_F123, 32'h0000_0123},
    {8'h10, 32'hFFFF_FFFF, 32'h1111_1111},
    {8'h10, 32'h0000_0000, 32'h0000_0000},
    {8'h18, 32'hFFFF_FFFF, 32'h0000_1111},
    {8'h18, 32'h0000_0000, 32'h0000_0000},
    {8'h1C, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {8'h14, 32'hFFFF_FFFF, 32'h0000_0FFF},
    {8'h14, 32'h0000_0000, 32'h0000_0000},
    {8'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h10, 32'hEEEE_EEEE, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a[4:0]; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a[4:0];
    #0.5;
    d = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    edges(3);
    rst_n = 1'b1;
    edges(2);

    // R1 reset state
    foreach (VEC[k]) begin
      rd(VEC[k][71:64], r);
      check("R1", r, 32'h0);
    end
    check("R1", {20'h0, pin_out}, 32'h0);
    check("R1", {20'h0, pin_oe}, 32'h0);
    check("R1", {31'h0, irq}, 32'h0);

    // register table: R2, R3, R4, R8, R9
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][71:64], VEC[k][63:32]);
      rd(VEC[k][71:64], r);
      check("R2/R3/R4/R8/R9 table", r, VEC[k][31:0]);
    end
    check("R2", {20'h0, pin_out}, 32'h0000_0A5A);
    check("R2", {20'h0, pin_oe}, 32'h0000_0123);

    // R9 mux write has no effect on pins
    wr(8'h1C, 32'h0000_0000);
    check("R9", {20'h0, pin_out}, 32'h0000_0A5A);
    check("R9", {20'h0, pin_oe}, 32'h0000_0123);
    check("R9", {31'h0, irq}, 32'h0);

    // clear status left over from the active-low table entries (R6)
    wr(8'h0C, 32'h0000_0FFF);
    edges(2);
    rd(8'h0C, r);
    check("R4 ignored bits keep pins active-high", r, 32'h0);

    // R3 synchronizer latency
    @(negedge clk);
    pin_in = 12'h5A3;
    @(negedge clk);
    rd(8'h08, r);
    check("R3 one edge", r, 32'h0);
    @(negedge clk);
    rd(8'h08, r);
    check("R3 two edges", r, 32'h0000_05A3);
    rd(8'h0C, r);
    check("R5 not yet", r, 32'h0);
    @(negedge clk);
    rd(8'h0C, r);
    check("R5 active-high latch", r, 32'h0000_05A3);
    check("R8 masked no irq", {31'h0, irq}, 32'h0);

    // R8 mask gating
    wr(8'h14, 32'h0000_0001);
    check("R8 enabled irq", {31'h0, irq}, 32'h1);
    wr(8'h14, 32'h0000_0004);
    check("R8 other pin only", {31'h0, irq}, 32'h0);

    // R6 write-one-to-clear with sources gone
    pin_in = 12'h000;
    edges(3);
    wr(8'h0C, 32'h0000_0001);
    rd(8'h0C, r);
    check("R6 clear one", r, 32'h0000_05A2);
    wr(8'h0C, 32'h0000_0000);
    rd(8'h0C, r);
    check("R6 zero write", r, 32'h0000_05A2);
    wr(8'h0C, 32'h0000_0FFF);
    edges(1);
    rd(8'h0C, r);
    check("R6 clear all", r, 32'h0);

    // R7 re-latch while still active
    pin_in = 12'h010;
    edges(3);
    rd(8'h0C, r);
    check("R7 set", r, 32'h0000_0010);
    wr(8'h0C, 32'h0000_0010);
    rd(8'h0C, r);
    check("R7 cleared one cycle", r, 32'h0);
    @(negedge clk);
    rd(8'h0C, r);
    check("R7 re-latched", r, 32'h0000_0010);

    // R5 active-low on pin 9 via second polarity word, bit 4
    pin_in = 12'h000;
    edges(3);
    wr(8'h0C, 32'h0000_0FFF);
    rd(8'h0C, r);
    check("R6 cleared", r, 32'h0);
    wr(8'h18, 32'h0000_0010);
    @(negedge clk);
    rd(8'h0C, r);
    check("R5 active-low latch", r, 32'h0000_0200);
    wr(8'h14, 32'h0000_0200);
    check("R8 pin9 irq", {31'h0, irq}, 32'h1);
    pin_in = 12'h200;
    edges(3);
    wr(8'h0C, 32'h0000_0200);
    edges(2);
    rd(8'h0C, r);
    check("R5 inactive high stays clear", r, 32'h0);
    check("R8 irq drops", {31'h0, irq}, 32'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule